// File: doc/BRIEF.md
# Serial Port Baud and Bit-Clock Generator

This block produces the timing strobes for a serial port's transmitter and receiver. A reloadable down-counter clocked by the system clock divides it by a programmed divisor N plus one. Its zero-crossing strobe goes straight to the receiver's recovery logic as the receive base enable. A second divider stage derives the slower transmit enable from the same strobe.

The port has four clocking modes: plain asynchronous, asynchronous at doubled rate, synchronous with a locally generated bit clock, and synchronous with a bit clock supplied from outside. In the locally generated synchronous mode the block drives a square wave on the external bit-clock pin and enables that pin's driver. In the externally clocked mode it synchronises the pin and turns its edges into the two enables. In that mode the counter still runs, but nothing uses its output.

Software writes the 12-bit divisor as two bytes. The upper part goes into a holding register and takes effect only when the lower byte is written. Writing the lower byte restarts the counter and the transmit stage at once.

Top module: `sio_baud_gen`

## Requirements
- R1: Reset clears the divisor, the counter, the transmit stage and the pin toggle. With the divisor at zero after reset in plain asynchronous mode, rx_en is high on every cycle, tx_en pulses once in every 16 cycles, and xck_oe and xck_out are low.
- R2: Outside the externally clocked mode, rx_en pulses once every N+1 cycles, where N is the divisor.
- R3: In plain asynchronous mode (sync_sel=0, fast_async=0), tx_en pulses on every 16th rx_en pulse.
- R4: In doubled-rate asynchronous mode (sync_sel=0, fast_async=1), tx_en pulses on every 8th rx_en pulse.
- R5: In locally clocked synchronous mode (sync_sel=1, xck_dir_out=1), tx_en pulses on every 2nd rx_en pulse and xck_oe is high. xck_out starts at 0 after a lower-byte write and inverts on the cycle after each tx_en.
- R6: fast_async has no effect while sync_sel=1.
- R7: When the lower divisor byte is written in cycle k, the counter reloads at once. The first rx_en comes N cycles after cycle k, and the transmit stage restarts, so its first tx_en falls on the ratio-th rx_en after the write.
- R8: The upper divisor bits are taken from div_wdata[3:0] by a write of the upper byte. They are held and leave the running rate unchanged until the next lower-byte write, which loads {held bits, div_wdata}.
- R9: In externally clocked mode (sync_sel=1, xck_dir_out=0), xck_in passes through a two-stage synchroniser. Each rising edge gives one rx_en pulse and each falling edge gives one tx_en pulse, whatever the divisor. xck_oe and xck_out stay low.
- R10: In asynchronous modes xck_in has no effect, and xck_oe and xck_out are low.
- R11: Outside externally clocked mode, every tx_en pulse falls on a cycle in which rx_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi_wr | input | 1 | Write strobe for the upper divisor bits (held until the lower byte is written) |
| div_lo_wr | input | 1 | Write strobe for the lower divisor byte; reloads the counter |
| div_wdata | input | 8 | Write data for both divisor strobes |
| sync_sel | input | 1 | 1 selects synchronous operation |
| fast_async | input | 1 | 1 selects doubled rate in asynchronous mode |
| xck_dir_out | input | 1 | Bit-clock pin direction in synchronous mode: 1 drives it, 0 receives it |
| xck_in | input | 1 | Raw level of the external bit-clock pin |
| tx_en | output | 1 | Transmit bit-clock enable |
| rx_en | output | 1 | Receive base clock enable |
| xck_out | output | 1 | Level driven onto the bit-clock pin |
| xck_oe | output | 1 | Output enable of the bit-clock pin |

## Verification
The checker watches every cycle for the invariants that hold at any moment. These are: tx_en coincides with rx_en in the internally clocked modes, the pin stays undriven outside locally clocked mode, the two strobes never coincide when the clock comes from outside, xck_out inverts exactly on the cycle after each tx_en and otherwise holds, rx_en is quiet right after a write of a non-zero divisor, and the outputs stay quiet during reset. Exact periods and phases cannot be expressed as these short properties, so the bench shows them. It sweeps divisors 0 to 7 across all internal modes and checks each cycle's strobes and pin level against arithmetic predictions. It also shows the staged upper byte taking effect only on the lower-byte write, and the pulse counts produced by an external clock.

// File: rtl/sio_baud_pkg.sv
package sio_baud_pkg;

   typedef enum logic [1:0] {
      CLK_ASYNC_X16   = 2'd0,
      CLK_ASYNC_X8    = 2'd1,
      CLK_SYNC_MASTER = 2'd2,
      CLK_SYNC_SLAVE  = 2'd3
   } clk_mode_e;

   // Direction bit matters only when synchronous; speed bit only when not.
   function automatic clk_mode_e decode_mode(input logic sync_sel,
                                             input logic fast,
                                             input logic pin_out);
      if (sync_sel)
         return pin_out ? CLK_SYNC_MASTER : CLK_SYNC_SLAVE;
      return fast ? CLK_ASYNC_X8 : CLK_ASYNC_X16;
   endfunction

endpackage

// File: rtl/sio_div_counter.sv
module sio_div_counter #(
   parameter int DIV_W  = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              tick
);
   localparam int HI_W = DIV_W - BYTE_W;

   logic [HI_W-1:0]  hi_stage;
   logic [DIV_W-1:0] divisor;
   logic [DIV_W-1:0] count;
   logic [DIV_W-1:0] new_div;

   assign new_div = {hi_stage, wdata};

   generate
      if (HI_W < BYTE_W) begin : g_spare_bits
         logic unused_spare_bits;
         assign unused_spare_bits = ^wdata[BYTE_W-1:HI_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_stage <= '0;
         divisor  <= '0;
         count    <= '0;
      end else begin
         if (hi_wr)
            hi_stage <= wdata[HI_W-1:0];
         if (lo_wr) begin
            divisor <= new_div;
            count   <= new_div;
         end else if (count == '0) begin
            count <= divisor;
         end else begin
            count <= count - 1'b1;
         end
      end
   end

   assign tick = (count == '0);

endmodule

// File: rtl/sio_tx_prescale.sv
module sio_tx_prescale #(
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [PRE_W-1:0] terminal,
   output logic             pulse
);
   logic [PRE_W-1:0] phase;
   logic             at_end;

   assign at_end = (phase == terminal);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (clr)
         phase <= '0;
      else if (tick)
         phase <= at_end ? '0 : phase + 1'b1;
   end

   assign pulse = tick && at_end;

endmodule

// File: rtl/sio_xclk_sync.sv
module sio_xclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic chain [STAGES];
   logic prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[i] <= 1'b0;
               else if (!en) chain[i] <= 1'b0;
               else          chain[i] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[i] <= 1'b0;
               else if (!en) chain[i] <= 1'b0;
               else          chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev <= 1'b0;
      else if (!en) prev <= 1'b0;
      else          prev <= chain[STAGES-1];
   end

   assign rise = en &&  chain[STAGES-1] && !prev;
   assign fall = en && !chain[STAGES-1] &&  prev;

endmodule

// File: rtl/sio_baud_gen.sv
module sio_baud_gen
   import sio_baud_pkg::*;
#(
   parameter int DIV_W         = 12,
   parameter int BYTE_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int TX_RATIO_X16  = 16,
   parameter int TX_RATIO_X8   = 8,
   parameter int TX_RATIO_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              div_hi_wr,
   input  logic              div_lo_wr,
   input  logic [BYTE_W-1:0] div_wdata,
   input  logic              sync_sel,
   input  logic              fast_async,
   input  logic              xck_dir_out,
   input  logic              xck_in,
   output logic              tx_en,
   output logic              rx_en,
   output logic              xck_out,
   output logic              xck_oe
);
   localparam int PRE_W = $clog2(TX_RATIO_X16);
   localparam logic [PRE_W-1:0] TERM_X16  = PRE_W'(TX_RATIO_X16 - 1);
   localparam logic [PRE_W-1:0] TERM_X8   = PRE_W'(TX_RATIO_X8 - 1);
   localparam logic [PRE_W-1:0] TERM_SYNC = PRE_W'(TX_RATIO_SYNC - 1);

   generate
      if (DIV_W <= BYTE_W || DIV_W > 2 * BYTE_W) begin : g_bad_div_w
         $error("sio_baud_gen: DIV_W must lie above BYTE_W and at most twice it");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sio_baud_gen: SYNC_STAGES must be at least 2");
      end
      if (TX_RATIO_SYNC < 2 || TX_RATIO_X8 < TX_RATIO_SYNC || TX_RATIO_X16 < TX_RATIO_X8) begin : g_bad_ratio
         $error("sio_baud_gen: transmit ratios must be ordered and at least 2");
      end
   endgenerate

   clk_mode_e        mode;
   logic             is_master;
   logic             is_slave;
   logic [PRE_W-1:0] terminal;
   logic             gen_tick;
   logic             int_tx;
   logic             ext_rise;
   logic             ext_fall;
   logic             pin_q;

   assign mode      = decode_mode(sync_sel, fast_async, xck_dir_out);
   assign is_master = (mode == CLK_SYNC_MASTER);
   assign is_slave  = (mode == CLK_SYNC_SLAVE);

   always_comb begin
      unique case (mode)
         CLK_ASYNC_X8:    terminal = TERM_X8;
         CLK_SYNC_MASTER: terminal = TERM_SYNC;
         CLK_SYNC_SLAVE:  terminal = TERM_SYNC;
         default:         terminal = TERM_X16;
      endcase
   end

   sio_div_counter #(
      .DIV_W  (DIV_W),
      .BYTE_W (BYTE_W)
   ) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_wr (div_hi_wr),
      .lo_wr (div_lo_wr),
      .wdata (div_wdata),
      .tick  (gen_tick)
   );

   sio_tx_prescale #(
      .PRE_W (PRE_W)
   ) pre_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (div_lo_wr),
      .tick     (gen_tick),
      .terminal (terminal),
      .pulse    (int_tx)
   );

   sio_xclk_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (is_slave),
      .pin   (xck_in),
      .rise  (ext_rise),
      .fall  (ext_fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_q <= 1'b0;
      else if (!is_master || div_lo_wr)
         pin_q <= 1'b0;
      else if (int_tx)
         pin_q <= ~pin_q;
   end

   assign tx_en   = is_slave ? ext_fall : int_tx;
   assign rx_en   = is_slave ? ext_rise : gen_tick;
   assign xck_oe  = is_master;
   assign xck_out = pin_q && is_master;

endmodule

// File: rtl/sio_baud_chk.sv
module sio_baud_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              div_lo_wr,
   input logic [BYTE_W-1:0] div_wdata,
   input logic              sync_sel,
   input logic              xck_dir_out,
   input logic              tx_en,
   input logic              rx_en,
   input logic              xck_out,
   input logic              xck_oe
);
   logic master;
   logic slave;
   assign master = sync_sel && xck_dir_out;
   assign slave  = sync_sel && !xck_dir_out;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!tx_en && !xck_out));

   p_tx_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !slave) |-> rx_en);

   p_slave_idle_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slave |-> (!xck_oe && !xck_out && !(tx_en && rx_en)));

   p_async_pin_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_sel |-> (!xck_oe && !xck_out));

   p_master_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      master |-> xck_oe);

   p_master_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (master && $past(master) && $past(rst_n) && $past(tx_en) && !$past(div_lo_wr))
      |-> (xck_out != $past(xck_out)));

   p_master_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (master && $past(master) && $past(rst_n) && !$past(tx_en) && !$past(div_lo_wr))
      |-> $stable(xck_out));

   p_reload_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave && $past(rst_n) && $past(div_lo_wr) && ($past(div_wdata) != '0))
      |-> !rx_en);

endmodule

bind sio_baud_gen sio_baud_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .div_lo_wr   (div_lo_wr),
   .div_wdata   (div_wdata),
   .sync_sel    (sync_sel),
   .xck_dir_out (xck_dir_out),
   .tx_en       (tx_en),
   .rx_en       (rx_en),
   .xck_out     (xck_out),
   .xck_oe      (xck_oe)
);

// File: tb/sio_baud_gen_tb_top.sv
module sio_baud_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_hi_wr = 1'b0;
   logic       div_lo_wr = 1'b0;
   logic [7:0] div_wdata = 8'h00;
   logic       sync_sel = 1'b0;
   logic       fast_async = 1'b0;
   logic       xck_dir_out = 1'b0;
   logic       xck_in = 1'b0;
   logic       tx_en, rx_en, xck_out, xck_oe;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sio_baud_gen dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .div_hi_wr   (div_hi_wr),
      .div_lo_wr   (div_lo_wr),
      .div_wdata   (div_wdata),
      .sync_sel    (sync_sel),
      .fast_async  (fast_async),
      .xck_dir_out (xck_dir_out),
      .xck_in      (xck_in),
      .tx_en       (tx_en),
      .rx_en       (rx_en),
      .xck_out     (xck_out),
      .xck_oe      (xck_oe)
   );

   task automatic check(input bit ok, input string tag, input int actual, input int expected);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   // Ends at the negedge of the first cycle after the lower-byte write.
   task automatic program_div(input int hi, input int lo);
      @(negedge clk);
      div_hi_wr = 1'b1;
      div_wdata = 8'(hi);
      @(negedge clk);
      div_hi_wr = 1'b0;
      div_lo_wr = 1'b1;
      div_wdata = 8'(lo);
      @(negedge clk);
      div_lo_wr = 1'b0;
   endtask

   task automatic measure(input int n, input int ratio, input bit s, input bit f,
                          input bit d, input bit tog, input string tag_tx,
                          input string tag_pin);
      int win = 3 * ratio * (n + 1) + n + 1;
      int bad_rx = 0, bad_tx = 0, bad_pin = 0, tx_seen = 0;
      bit master = s && d;
      sync_sel = s; fast_async = f; xck_dir_out = d;
      program_div(0, n);
      for (int j = 0; j < win; j++) begin
         bit e_rx, e_tx, e_ck;
         if (j > 0) @(negedge clk);
         e_rx = (j >= n) && (((j - n) % (n + 1)) == 0);
         e_tx = e_rx && ((((j - n) / (n + 1)) % ratio) == ratio - 1);
         e_ck = master ? tx_seen[0] : 1'b0;
         if (rx_en !== e_rx) bad_rx++;
         if (tx_en !== e_tx) bad_tx++;
         if (xck_out !== e_ck || xck_oe !== master) bad_pin++;
         if (e_tx) tx_seen++;
         if (tog) xck_in = ~xck_in;
      end
      check(bad_rx == 0, $sformatf("R2 R7 rx cadence n=%0d mode=%0d%0d%0d mismatching cycles", n, s, f, d), bad_rx, 0);
      check(bad_tx == 0, $sformatf("%s tx cadence n=%0d ratio=%0d mismatching cycles", tag_tx, n, ratio), bad_tx, 0);
      check(bad_pin == 0, $sformatf("%s pin level n=%0d mismatching cycles", tag_pin, n), bad_pin, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int rx_ones = 0, tx_cnt = 0, pin_bad = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: divisor 0 after reset, plain asynchronous mode
      for (int j = 0; j < 32; j++) begin
         @(negedge clk);
         rx_ones += int'(rx_en);
         tx_cnt  += int'(tx_en);
         if (xck_oe || xck_out) pin_bad++;
      end
      check(rx_ones == 32, "R1 rx every cycle after reset", rx_ones, 32);
      check(tx_cnt == 2, "R1 tx pulses in 32 cycles after reset", tx_cnt, 2);
      check(pin_bad == 0, "R1 pin idle after reset", pin_bad, 0);

      for (int n = 0; n < 8; n++) begin
         measure(n, 16, 1'b0, 1'b0, 1'b0, 1'b1, "R3", "R10");
         measure(n, 8,  1'b0, 1'b1, 1'b1, 1'b1, "R4", "R10");
         measure(n, 2,  1'b1, 1'b0, 1'b1, 1'b0, "R5", "R5");
         measure(n, 2,  1'b1, 1'b1, 1'b1, 1'b0, "R6", "R6");
      end

      // R8: upper byte write alone leaves rate unchanged
      begin
         int bad = 0, first = -1;
         sync_sel = 1'b0; fast_async = 1'b0; xck_dir_out = 1'b0;
         program_div(0, 3);
         for (int j = 0; j < 40; j++) begin
            if (j > 0) @(negedge clk);
            if (j == 5) begin div_hi_wr = 1'b1; div_wdata = 8'h0F; end
            if (j == 6) div_hi_wr = 1'b0;
            if (rx_en !== ((j >= 3) && (((j - 3) % 4) == 0))) bad++;
         end
         check(bad == 0, "R8 held upper bits do not change running rate", bad, 0);
         @(negedge clk);
         div_lo_wr = 1'b1;
         div_wdata = 8'h02;
         @(negedge clk);
         div_lo_wr = 1'b0;
         for (int j = 0; j < 4000; j++) begin
            if (j > 0) @(negedge clk);
            if (rx_en && first < 0) first = j;
         end
         check(first == 3842, "R8 first rx after lower write with held 0xF", first, 3842);
      end

      // R9: external clock, divisor 0 so counter would tick every cycle
      begin
         int rc = 0, fc = 0, pb = 0;
         sync_sel = 1'b1; fast_async = 1'b0; xck_dir_out = 1'b0; xck_in = 1'b0;
         program_div(0, 0);
         for (int p = 0; p < 10; p++) begin
            for (int h = 0; h < 10; h++) begin
               xck_in = (h < 5);
               @(negedge clk);
               rc += int'(rx_en);
               fc += int'(tx_en);
               if (xck_oe || xck_out) pb++;
            end
         end
         for (int h = 0; h < 6; h++) begin
            @(negedge clk);
            rc += int'(rx_en);
            fc += int'(tx_en);
         end
         check(rc == 10, "R9 rx pulses per external rising edge", rc, 10);
         check(fc == 10, "R9 tx pulses per external falling edge", fc, 10);
         check(pb == 0, "R9 pin not driven when externally clocked", pb, 0);
      end

      // R11 is covered cycle by cycle in the measured sweeps; one direct look here
      begin
         int stray = 0;
         sync_sel = 1'b0; fast_async = 1'b1; xck_dir_out = 1'b0;
         program_div(0, 1);
         for (int j = 0; j < 64; j++) begin
            @(negedge clk);
            if (tx_en && !rx_en) stray++;
         end
         check(stray == 0, "R11 tx only with rx", stray, 0);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule